// File: doc/BRIEF.md
# Self-Timed Rendezvous Pipeline Controller

This block is a cycle-accurate model of a self-timed, bundled-data FIFO pipeline. Each stage has three parts: a state-holding rendezvous element, a data latch, and a matched-delay line on the incoming request. A rendezvous element changes its output only when both of its inputs agree. Its first input is the delayed request from the stage on its left. Its second input is the inverted state of the stage on its right. At reset every element output is 0, so the two inputs of each element differ and every stage starts empty.

A stage takes a new word when the stage before it is full and the stage after it is empty. At that moment its output toggles, its latch captures the word, the stage on the left is marked empty, and the stage on the right is marked full.

Both sides of the block use two-phase transition signalling. A producer offers a word by holding it on `in_data` and toggling `in_req`. The block accepts the word by toggling `in_ack` until it matches `in_req`. On the right, a pending word is shown by `out_req` differing from `out_ack`. The consumer takes the word by toggling `out_ack`. Each matched delay is a whole number of clock cycles, and every hop through a stage costs that delay plus one cycle.

Top module: `selftimed_pipe`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `in_ack` is 0, `out_req` is 0 and `occupancy` is 0.
- R2: `in_ack` changes only when, at the previous clock edge, `in_req` differed from `in_ack`. A change always makes `in_ack` equal to `in_req`. While the two are equal, `in_ack` holds.
- R3: Words leave on `out_data` in the order they were accepted on `in_data`, with none lost and none duplicated.
- R4: In an empty pipeline, `in_req` is toggled just after clock edge 0. The first rising edge at which `out_req` toggles is then edge number NUM_STAGES*(DELAY+1).
- R5: When `out_ack` is held, exactly NUM_STAGES words are accepted. A further offered word stays unacknowledged for as long as `out_ack` is held. It is accepted after the consumer takes one word. `occupancy` never exceeds NUM_STAGES, and while it equals NUM_STAGES, `in_ack` does not change at the next edge.
- R6: In every cycle, `occupancy` equals the number of `in_ack` toggles since reset minus the number of `out_ack` toggles since reset.
- R7: While `out_req` differs from `out_ack`, neither `out_req` nor `out_data` changes at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times the cycle model |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Left request; each transition offers a word |
| in_data | input | DATA_W | Word bundled with the left request |
| in_ack | output | 1 | Left acknowledge; toggles when the offered word is taken |
| out_req | output | 1 | Right request; toggles when a word is presented |
| out_data | output | DATA_W | Word presented to the consumer |
| out_ack | input | 1 | Right acknowledge; a toggle releases the presented word |
| occupancy | output | $clog2(NUM_STAGES+1) | Number of stages holding a word |

## Verification
The bench fills the pipeline against a stalled consumer and checks that the extra word waits. A design that is off by one in the full or empty test would either take an extra word and overwrite one in flight, or stop a stage short. It times one word through an empty pipeline, which catches a delay line with the wrong length or a stage that skips its rendezvous. Under random producer gaps and random consumer stalls, it follows word order and occupancy on every cycle. These checks expose latches that capture on the wrong transition, a wrong inverter polarity that lets neighbouring stages fire together, and a count that miscomputes full stages at the right-hand end.

// File: rtl/selftimed_pipe_pkg.sv
package selftimed_pipe_pkg;

  // Next state of a two-input rendezvous element: follow the inputs when they
  // agree, otherwise keep the present value.
  function automatic logic rv_next(input logic a, input logic b, input logic q);
    return (a == b) ? a : q;
  endfunction

endpackage

// File: rtl/rv_element.sv
module rv_element
  import selftimed_pipe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_a,
  input  logic in_b,
  output logic state,
  output logic fire
);

  logic nxt;

  always_comb begin
    nxt  = rv_next(in_a, in_b, state);
    fire = (nxt != state);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= 1'b0;
    else     state <= nxt;
  end

endmodule

// File: rtl/req_delay_line.sv
module req_delay_line #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [DELAY-1:0] taps;

  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else begin
      taps[0] <= din;
      for (int k = 1; k < DELAY; k++) taps[k] <= taps[k-1];
    end
  end

  assign dout = taps[DELAY-1];

endmodule

// File: rtl/stage_latch.sv
module stage_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (capture) q <= d;
  end

endmodule

// File: rtl/selftimed_pipe.sv
module selftimed_pipe #(
  parameter int NUM_STAGES = 4,
  parameter int DATA_W     = 8,
  parameter int DELAY      = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_req,
  input  logic [DATA_W-1:0]               in_data,
  output logic                            in_ack,
  output logic                            out_req,
  output logic [DATA_W-1:0]               out_data,
  input  logic                            out_ack,
  output logic [$clog2(NUM_STAGES+1)-1:0] occupancy
);

  localparam int OCC_W = $clog2(NUM_STAGES + 1);

  logic [NUM_STAGES-1:0] st;        // element outputs
  logic [NUM_STAGES-1:0] fire;      // element about to toggle
  logic [NUM_STAGES-1:0] req_src;   // undelayed request into each stage
  logic [NUM_STAGES-1:0] req_dly;   // request after matched delay
  logic [NUM_STAGES-1:0] right_st;  // state of the right-hand neighbour
  logic [NUM_STAGES-1:0] full;
  logic [DATA_W-1:0]     word  [NUM_STAGES];
  logic [DATA_W-1:0]     w_src [NUM_STAGES];

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign req_src[i] = in_req;
      assign w_src[i]   = in_data;
    end else begin : g_body
      assign req_src[i] = st[i-1];
      assign w_src[i]   = word[i-1];
    end

    if (i == NUM_STAGES - 1) begin : g_tail
      assign right_st[i] = out_ack;
    end else begin : g_mid
      assign right_st[i] = st[i+1];
    end

    req_delay_line #(.DELAY(DELAY)) u_dly (
      .clk  (clk),
      .rst  (rst),
      .din  (req_src[i]),
      .dout (req_dly[i])
    );

    rv_element u_rv (
      .clk   (clk),
      .rst   (rst),
      .in_a  (req_dly[i]),
      .in_b  (~right_st[i]),
      .state (st[i]),
      .fire  (fire[i])
    );

    stage_latch #(.DATA_W(DATA_W)) u_lat (
      .clk     (clk),
      .rst     (rst),
      .capture (fire[i]),
      .d       (w_src[i]),
      .q       (word[i])
    );

    assign full[i] = st[i] ^ right_st[i];
  end

  always_comb begin
    occupancy = '0;
    for (int i = 0; i < NUM_STAGES; i++) occupancy = occupancy + OCC_W'(full[i]);
  end

  assign in_ack   = st[0];
  assign out_req  = st[NUM_STAGES-1];
  assign out_data = word[NUM_STAGES-1];

endmodule

// File: rtl/selftimed_pipe_chk.sv
module selftimed_pipe_chk #(
  parameter int NUM_STAGES = 4,
  parameter int DATA_W     = 8
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            in_req,
  input logic                            in_ack,
  input logic                            out_req,
  input logic                            out_ack,
  input logic [DATA_W-1:0]               out_data,
  input logic [$clog2(NUM_STAGES+1)-1:0] occupancy
);

  AST_ACK_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (in_ack != $past(in_ack)) |-> ($past(in_req) != $past(in_ack))); // R2

  AST_ACK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (in_req == in_ack) |=> $stable(in_ack)); // R2

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    (32'(occupancy) <= NUM_STAGES)); // R5

  AST_FULL_BLOCKS_LEFT: assert property (@(posedge clk) disable iff (rst)
    (32'(occupancy) == NUM_STAGES) |=> $stable(in_ack)); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_req != out_ack) |=> ($stable(out_req) && $stable(out_data))); // R7

endmodule

bind selftimed_pipe selftimed_pipe_chk #(
  .NUM_STAGES(NUM_STAGES),
  .DATA_W    (DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_req   (in_req),
  .in_ack   (in_ack),
  .out_req  (out_req),
  .out_ack  (out_ack),
  .out_data (out_data),
  .occupancy(occupancy)
);

// File: tb/selftimed_pipe_tb_top.sv
module selftimed_pipe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int D  = 2;
  localparam int OW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_req = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          in_ack;
  logic          out_req;
  logic [W-1:0]  out_data;
  logic          out_ack = 1'b0;
  logic [OW-1:0] occupancy;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] exp_mem [0:1023];
  int wr_idx = 0;
  int rd_idx = 0;
  bit mon_on = 1'b0;
  int acc_cnt = 0;
  int rem_cnt = 0;
  logic prev_ack, prev_oack;

  always #(CLK_PERIOD/2) clk = ~clk;

  selftimed_pipe #(.NUM_STAGES(N), .DATA_W(W), .DELAY(D)) dut_i (
    .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data), .in_ack(in_ack),
    .out_req(out_req), .out_data(out_data), .out_ack(out_ack), .occupancy(occupancy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expected_latency(input int stages, input int dly);
    return stages * (dly + 1);
  endfunction

  task automatic offer(input logic [W-1:0] w);
    @(posedge clk); #1;
    in_data = w;
    in_req  = ~in_req;
    exp_mem[wr_idx] = w;
    wr_idx++;
  endtask

  task automatic wait_taken();
    do @(negedge clk); while (in_ack != in_req);
  endtask

  task automatic take(input int stall);
    do @(negedge clk); while (out_req == out_ack);
    check(out_data == exp_mem[rd_idx], "R3 word order", int'(out_data), int'(exp_mem[rd_idx]));
    rd_idx++;
    repeat (stall) @(posedge clk);
    @(posedge clk); #1;
    out_ack = ~out_ack;
  endtask

  // R6: occupancy against accepted minus removed, every cycle
  always @(negedge clk) begin
    if (mon_on) begin
      if (in_ack  != prev_ack)  acc_cnt++;
      if (out_ack != prev_oack) rem_cnt++;
      prev_ack  = in_ack;
      prev_oack = out_ack;
      check(int'(occupancy) == acc_cnt - rem_cnt, "R6 occupancy", int'(occupancy), acc_cnt - rem_cnt);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ack == 1'b0 && out_req == 1'b0, "R1 reset handshake", int'({in_ack, out_req}), 0);
    check(occupancy == '0, "R1 reset occupancy", int'(occupancy), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(in_ack == 1'b0 && out_req == 1'b0 && occupancy == '0, "R1 first cycle after reset",
          int'({in_ack, out_req, occupancy}), 0);
    prev_ack  = in_ack;
    prev_oack = out_ack;
    mon_on    = 1'b1;

    // R2: no request transition, no acknowledge
    repeat (20) @(negedge clk);
    check(in_ack == 1'b0, "R2 idle ack", int'(in_ack), 0);

    // R4: latency through the empty pipeline
    offer(8'hA5);
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (out_req == out_ack && lat < 200);
    check(lat == expected_latency(N, D), "R4 empty latency", lat, expected_latency(N, D));
    check(in_ack == in_req, "R2 ack follows req", int'(in_ack), int'(in_req));
    check(out_data == 8'hA5, "R3 first word", int'(out_data), 8'hA5);
    take(0);

    // R5: capacity against a stalled consumer
    for (int k = 0; k < N; k++) begin
      offer(8'h10 + 8'(k));
      wait_taken();
    end
    repeat (4 * (D + 1)) @(negedge clk);
    check(int'(occupancy) == N, "R5 full occupancy", int'(occupancy), N);
    offer(8'h3C);
    repeat (10 * (D + 1)) @(negedge clk);
    check(in_ack != in_req, "R5 extra word not taken", int'(in_ack), int'(~in_req));
    check(out_data == 8'h10, "R7 presented word held", int'(out_data), 8'h10);
    take(0);
    wait_taken();
    check(in_ack == in_req, "R5 extra word taken after drain", int'(in_ack), int'(in_req));
    for (int k = 0; k < N; k++) take(0);
    check(rd_idx == wr_idx, "R3 all words out", rd_idx, wr_idx);

    // R3 R6: random producer and consumer
    fork
      begin
        for (int k = 0; k < 60; k++) begin
          repeat ($urandom_range(0, 3)) @(posedge clk);
          offer(8'($urandom));
          wait_taken();
        end
      end
      begin
        for (int k = 0; k < 60; k++) take(int'($urandom_range(0, 6)));
      end
    join
    repeat (5) @(negedge clk);
    check(rd_idx == wr_idx, "R3 random all delivered", rd_idx, wr_idx);
    check(occupancy == '0, "R6 drained occupancy", int'(occupancy), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule